// File: doc/BRIEF.md
# Lamp Drive Fault-Retry Sequencer

This block is the supervisory state machine of a resonant lamp-drive controller. It watches five comparator flags: supply valid, shutdown pin above its upper threshold, shutdown pin below its lower threshold, open-lamp detect and error-amplifier no-lock. From these it decides when the oscillator runs, when the gate drivers may switch, and when the error amplifier and the shutdown-pin capacitor are held at their initial conditions. Every flag is resynchronised to the local clock before the machine uses it.

After the supply comes up and the pin is released, the machine passes through a timed startup phase. In that phase the amplifier output is forced to its maximum-frequency end and the pin capacitor is discharged. The machine then runs until a fault appears. An open lamp or a failure to lock consumes one of a limited number of retries and restarts the sequence. When the retries run out, the machine locks into an error shutdown. In that state the oscillator keeps running and the gates stay off, until the supply is lost or the pin is driven high and then low again.

Top module: `lamp_retry_seq`

## Requirements
- R1: While the synchronised supply flag is low, the oscillator enable, gate enable, precondition and discharge outputs are low and the retry count is zero, from any state.
- R2: With the supply valid, a high pin-above-upper flag enters shutdown from any state: the low-power flag is set, the oscillator and gate enables are low and the retry count is cleared.
- R3: Shutdown and undervoltage are left towards startup only while the pin-below-lower flag is high; with both pin flags low the block stays where it is.
- R4: Startup lasts exactly PRECOND_CYCLES (default 16) clock cycles. During it, precondition, discharge, oscillator enable and gate enable are all high. It is then followed by normal operation.
- R5: In normal operation, oscillator and gate enables are high and precondition, discharge and low-power are low.
- R6: An open-lamp or no-lock flag during normal operation raises the retry count by one, by exactly one when both are present together. It gives one cycle of fault handling with the enables kept high, and then a new startup while the count is below RETRY_LIMIT (default 7).
- R7: The fault that brings the count to RETRY_LIMIT leads to error shutdown: oscillator enable high, gate enable low, the count held at RETRY_LIMIT.
- R8: Error shutdown ignores open-lamp, no-lock and pin-below-lower activity. Only loss of supply or a pin-above-upper event (followed later by pin-below-lower) leaves it, and both clear the count.
- R9: Simultaneous conditions are ranked as follows: undervoltage over user shutdown, and user shutdown over open-lamp and no-lock.
- R10: Every flag passes through two synchroniser flops. A change presented before clock edge n first changes the outputs after edge n+2.
- R11: An asserted active-low reset forces the undervoltage state at once, with all outputs low and the count zero, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_in | input | 1 | Supply above its undervoltage threshold (asynchronous) |
| pin_high_in | input | 1 | Shutdown pin above its upper threshold (asynchronous) |
| pin_low_in | input | 1 | Shutdown pin below its lower threshold (asynchronous) |
| open_lamp_in | input | 1 | Open-lamp detector flag (asynchronous) |
| no_lock_in | input | 1 | Error amplifier reached its upper limit without regulation (asynchronous) |
| osc_en | output | 1 | Oscillator enable |
| gate_en | output | 1 | Gate drivers may switch; low forces their off levels |
| ea_precond | output | 1 | Hold error-amplifier output at the maximum-frequency end |
| pin_discharge | output | 1 | Discharge the shutdown-pin capacitor |
| low_power | output | 1 | Low-power shutdown indication |
| retry_cnt | output | CNT_W | Faults consumed since the last clear |

## Verification
The assertions assume that the comparator flags are consistent once synchronised. The pin cannot be reported both above the upper and below the lower threshold, and supply loss may arrive at any time. The stimulus only ever raises one pin flag at a time. It holds or pulses the fault flags for whole clock periods, so the reference model and the design see the same synchronised history. Faults are applied in normal operation, during startup, during error shutdown and together with shutdown or supply loss. These cases exercise the ranking and the lockout.

// File: rtl/lamp_retry_seq.sv
module lamp_retry_seq #(
  parameter int PRECOND_CYCLES = 16,
  parameter int RETRY_LIMIT    = 7,
  parameter int CNT_W          = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok_in,
  input  logic             pin_high_in,
  input  logic             pin_low_in,
  input  logic             open_lamp_in,
  input  logic             no_lock_in,
  output logic             osc_en,
  output logic             gate_en,
  output logic             ea_precond,
  output logic             pin_discharge,
  output logic             low_power,
  output logic [CNT_W-1:0] retry_cnt
);
  localparam int NFLAG   = 5;
  localparam int CHAIN_W = SYNC_STAGES * NFLAG;
  localparam int TMR_W   = (PRECOND_CYCLES > 1) ? $clog2(PRECOND_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(PRECOND_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RETRY_LIMIT);

  typedef enum logic [2:0] {
    ST_UV, ST_OFF, ST_INIT, ST_RUN, ST_OPEN, ST_NOLOCK, ST_LOCKOUT
  } st_t;

  st_t               st, st_n;
  logic [TMR_W-1:0]  tmr;
  logic [CHAIN_W-1:0] chain;
  logic [NFLAG-1:0]  raw, flg;
  logic              s_sup, s_hi, s_lo, s_open, s_nl;

  assign raw = {no_lock_in, open_lamp_in, pin_low_in, pin_high_in, supply_ok_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-NFLAG-1:0], raw};

  assign flg    = chain[CHAIN_W-1 -: NFLAG];
  assign s_sup  = flg[0];
  assign s_hi   = flg[1];
  assign s_lo   = flg[2];
  assign s_open = flg[3];
  assign s_nl   = flg[4];

  always_comb begin
    st_n = st;
    if (!s_sup)      st_n = ST_UV;
    else if (s_hi)   st_n = ST_OFF;
    else begin
      case (st)
        ST_UV, ST_OFF:     if (s_lo) st_n = ST_INIT;
        ST_INIT:           if (tmr == TMR_LAST) st_n = ST_RUN;
        ST_RUN:            if (s_open) st_n = ST_OPEN;
                           else if (s_nl) st_n = ST_NOLOCK;
        ST_OPEN, ST_NOLOCK: st_n = (retry_cnt == CNT_MAX) ? ST_LOCKOUT : ST_INIT;
        ST_LOCKOUT:        st_n = ST_LOCKOUT;
        default:           st_n = ST_UV;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= ST_UV;
      tmr       <= '0;
      retry_cnt <= '0;
    end else begin
      st  <= st_n;
      tmr <= (st == ST_INIT && st_n == ST_INIT) ? tmr + 1'b1 : '0;
      if (st_n == ST_UV || st_n == ST_OFF)
        retry_cnt <= '0;
      else if (st == ST_RUN && (st_n == ST_OPEN || st_n == ST_NOLOCK) && retry_cnt != CNT_MAX)
        retry_cnt <= retry_cnt + 1'b1;
    end

  assign osc_en        = (st == ST_INIT) || (st == ST_RUN) || (st == ST_OPEN) ||
                         (st == ST_NOLOCK) || (st == ST_LOCKOUT);
  assign gate_en       = (st == ST_INIT) || (st == ST_RUN) || (st == ST_OPEN) || (st == ST_NOLOCK);
  assign ea_precond    = (st == ST_INIT);
  assign pin_discharge = (st == ST_INIT);
  assign low_power     = (st == ST_OFF);

  a_r1_uv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !s_sup |=> (!osc_en && !gate_en && !ea_precond && retry_cnt == '0));

  a_r2_off_lowpower: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sup && s_hi) |=> (low_power && !osc_en && !gate_en && retry_cnt == '0));

  a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && s_sup && !s_lo) |=> (!osc_en && !gate_en));

  a_r4_precond_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ea_precond |-> (osc_en && gate_en && pin_discharge && !low_power));

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_cnt != $past(retry_cnt)) |->
      (retry_cnt == CNT_W'($past(retry_cnt) + 1'b1) || retry_cnt == '0));

  a_r7_lockout_out: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCKOUT) |-> (retry_cnt == CNT_MAX && osc_en && !gate_en));

  a_r8_lockout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCKOUT && s_sup && !s_hi) |=> (st == ST_LOCKOUT));

  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!osc_en && !gate_en && !low_power && retry_cnt == '0));
endmodule

// File: tb/lamp_retry_seq_test.sv
module lamp_retry_seq_test;
  localparam int P = 16;
  localparam int L = 7;
  localparam int UV = 0, OFF = 1, INIT = 2, RUN = 3, FLT = 4, LOCK = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup = 0, hi = 0, lo = 0, opn = 0, nl = 0;
  logic osc_en, gate_en, ea_precond, pin_discharge, low_power;
  logic [2:0] retry_cnt;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_st, m_cnt, m_tmr;
  logic [4:0] pipe[$];

  always #2 clk = ~clk;

  lamp_retry_seq #(.PRECOND_CYCLES(P), .RETRY_LIMIT(L), .CNT_W(3), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok_in(sup), .pin_high_in(hi), .pin_low_in(lo),
    .open_lamp_in(opn), .no_lock_in(nl), .osc_en(osc_en), .gate_en(gate_en),
    .ea_precond(ea_precond), .pin_discharge(pin_discharge), .low_power(low_power),
    .retry_cnt(retry_cnt));

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = UV; m_cnt = 0; m_tmr = 0;
    pipe.delete();
    pipe.push_back(5'b0);
    pipe.push_back(5'b0);
  endtask

  task automatic model_edge();
    logic [4:0] f;
    int nx;
    f  = pipe.pop_front();
    pipe.push_back({nl, opn, lo, hi, sup});
    nx = m_st;
    if (!f[0])      nx = UV;
    else if (f[1])  nx = OFF;
    else if ((m_st == UV || m_st == OFF) && f[2]) nx = INIT;
    else if (m_st == INIT && m_tmr == P - 1) nx = RUN;
    else if (m_st == RUN && (f[3] || f[4])) begin
      nx = FLT;
      if (m_cnt < L) m_cnt++;
    end
    else if (m_st == FLT) nx = (m_cnt == L) ? LOCK : INIT;
    m_tmr = (m_st == INIT && nx == INIT) ? m_tmr + 1 : 0;
    if (nx == UV || nx == OFF) m_cnt = 0;
    m_st = nx;
  endtask

  function automatic string tag_of(int s);
    case (s)
      UV:   return "R1";
      OFF:  return "R2";
      INIT: return "R4";
      RUN:  return "R5";
      FLT:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    string t;
    t = tag_of(m_st);
    check(t, "osc_en", osc_en, (m_st == INIT || m_st == RUN || m_st == FLT || m_st == LOCK));
    check(t, "gate_en", gate_en, (m_st == INIT || m_st == RUN || m_st == FLT));
    check(t, "ea_precond", ea_precond, m_st == INIT);
    check(t, "pin_discharge", pin_discharge, m_st == INIT);
    check(t, "low_power", low_power, m_st == OFF);
    check(t, "retry_cnt", retry_cnt, m_cnt);
  endtask

  task automatic step();
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R11", "gate_en in reset", gate_en, 0);
    check("R11", "low_power in reset", low_power, 0);
    check("R11", "retry_cnt in reset", retry_cnt, 0);
    rst_n = 1'b1;
    run(2);
    check("R1", "osc_en no supply", osc_en, 0);

    sup = 1; lo = 1;
    step(); check("R10", "gate_en after 1 edge", gate_en, 0);
    step(); check("R10", "gate_en after 2 edges", gate_en, 0);
    step(); check("R10", "gate_en after 3 edges", gate_en, 1);
    check("R4", "ea_precond at startup", ea_precond, 1);
    run(P - 1); check("R4", "ea_precond last startup cycle", ea_precond, 1);
    step(); check("R4", "ea_precond after startup", ea_precond, 0);
    check("R5", "gate_en running", gate_en, 1);

    for (int i = 1; i <= L; i++) begin
      opn = 1; step(); opn = 0;
      run(P + 6);
      check("R6", "retry_cnt after open lamp", retry_cnt, i);
      if (i == L) begin
        check("R7", "osc_en in lockout", osc_en, 1);
        check("R7", "gate_en in lockout", gate_en, 0);
      end else check("R6", "gate_en after retry", gate_en, 1);
    end

    opn = 1; nl = 1; lo = 0; run(5); lo = 1; run(8);
    check("R8", "gate_en stays off", gate_en, 0);
    check("R8", "retry_cnt stays", retry_cnt, L);
    opn = 0; nl = 0;

    hi = 1; lo = 0; run(5);
    check("R2", "low_power", low_power, 1);
    check("R8", "count cleared by shutdown", retry_cnt, 0);
    hi = 0; run(8);
    check("R3", "stays off with pin mid-range", low_power, 1);
    lo = 1; run(4);
    check("R3", "startup after pin low", ea_precond, 1);
    run(P + 2);

    nl = 1; run(3 * (P + 4)); nl = 0; run(P + 6);
    check("R6", "no-lock retries counted", retry_cnt != 0, 1);
    sup = 0; run(4);
    check("R1", "count cleared by supply loss", retry_cnt, 0);
    check("R1", "gate_en off", gate_en, 0);
    sup = 1; run(P + 6);

    sup = 0; hi = 1; opn = 1; lo = 0; run(4);
    check("R9", "undervoltage beats shutdown", low_power, 0);
    check("R9", "undervoltage beats open lamp", osc_en, 0);
    opn = 0; sup = 1; run(4);
    check("R9", "shutdown once supply valid", low_power, 1);
    hi = 0; lo = 1; run(P + 6);
    check("R5", "running again", gate_en, 1);
    hi = 1; lo = 0; opn = 1; run(4);
    check("R9", "shutdown beats open lamp", low_power, 1);
    check("R9", "no retry consumed", retry_cnt, 0);
    hi = 0; lo = 1; opn = 0; run(P + 6);

    opn = 1; nl = 1; step(); opn = 0; nl = 0; run(P + 6);
    check("R6", "simultaneous faults count once", retry_cnt, 1);

    #1 rst_n = 1'b0;
    #1;
    check("R11", "osc_en async reset", osc_en, 0);
    check("R11", "retry_cnt async reset", retry_cnt, 0);
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    run(P + 6);
    check("R5", "running after reset", gate_en, 1);
    finish_up();
  end
endmodule